// File: doc/BRIEF.md
# Bus Fault Status Capture

This block watches bus transactions and records the first error in two registers. One is a status word. The other holds the address of the failing transaction. The errors it knows are:

- a write that completes with an error acknowledge;
- a write that does not complete within a fixed number of clock cycles;
- an error that the bus reports after a transaction has already ended.

The first error loads the whole status word and the address register. Any later error sets only a sticky multiple-error flag, so software still sees where the trouble began.

The block remembers the attributes of the most recent transaction, taken at its start strobe: direction, size, privilege mode and address. A captured error takes those attributes. A timeout counter runs only while a write is outstanding. An interrupt line follows the summary error bit. Software clears the captured state by writing the status register, which shows up here as a one-cycle clear strobe.

Top module: `bus_fault_capture`

## Requirements
- R1: After reset, and after a clear, the status word reads 0x0080_0000, the address register reads 0 and the interrupt is low.
- R2: A write that completes (`txn_done`) with `ack_err` high sets status bit 28. A read that completes with `ack_err` high records nothing.
- R3: Status bit 29 is set when a write has not completed within `TIMEOUT_CYC` cycles.
  - The count begins in the first cycle after the start strobe.
  - A completion in the last counted cycle prevents the timeout.
- R4: A one-cycle `late_err` pulse sets status bit 30. The error takes the attributes of the most recently started transaction.
- R5: Status bit 31 is the OR of bits 30, 29 and 28, and `irq_o` equals bit 31.
- R6: The first error loads the following fields:
  - size in bits [27:25];
  - the supervisor flag in bit 24;
  - bit 18 = 1 for a read and 0 for a write;
  - bit 17 = 1, meaning the address register is valid;
  - the transaction address into `fault_addr_o`.
- R7: Any error that arrives while bit 31 is already set changes only bit 19, setting it to 1. Every other status bit and the address register stay unchanged.
- R8: A `clr_stat` pulse returns every captured field to the R1 state. A clear has priority over an error in the same cycle.
- R9: Bits [23:20] of the status word always read 4'b1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Start strobe; latches the attributes of a new transaction |
| txn_done | input | 1 | Completion strobe for the outstanding transaction |
| txn_wr | input | 1 | Direction at start: 1 = write, 0 = read |
| txn_size | input | 3 | Transaction size code at start |
| txn_sup | input | 1 | Supervisor mode at start |
| txn_addr | input | ADDR_W | Transaction address at start |
| ack_err | input | 1 | Error acknowledge, qualified by `txn_done` |
| late_err | input | 1 | Bus error reported after a transaction ended |
| clr_stat | input | 1 | Status register write strobe; clears the captured state |
| fault_stat_o | output | 32 | Status word |
| fault_addr_o | output | ADDR_W | Address of the first failing transaction |
| irq_o | output | 1 | Interrupt, high while an error is held |

## Verification
Two cases are hard to reach from the ports.

The first is the timeout boundary: a completion in exactly the last counted cycle must not raise the timeout, and one cycle more must. The bench reaches it by holding `txn_done` back for an exact number of falling edges after the start strobe, one vector per side of the boundary.

The second is the collision of a clear with a new error. The bench reaches it by driving `clr_stat` and `late_err` in the same cycle while an earlier error is still held. It also produces a second error at a different address and checks that the first address survives.

// File: rtl/fault_pkg.sv
package fault_pkg;
    localparam int SIZE_W = 3;
    localparam logic [3:0] RSV_PATTERN = 4'b1000;

    // status word bit positions, decoded by software
    localparam int B_ERR  = 31;
    localparam int B_LATE = 30;
    localparam int B_TO   = 29;
    localparam int B_BE   = 28;
    localparam int B_SZ_H = 27;
    localparam int B_SZ_L = 25;
    localparam int B_SUP  = 24;
    localparam int B_ME   = 19;
    localparam int B_RD   = 18;
    localparam int B_FAV  = 17;

    typedef struct packed {
        logic late;
        logic tmo;
        logic berr;
        logic multi;
        logic rd;
        logic sup;
        logic fav;
        logic [SIZE_W-1:0] size;
    } cap_flags_t;
endpackage

// File: rtl/fault_txn_track.sv
module fault_txn_track #(
    parameter int ADDR_W      = 32,
    parameter int TIMEOUT_CYC = 320
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       txn_start,
    input  logic                       txn_done,
    input  logic                       txn_wr,
    input  logic [fault_pkg::SIZE_W-1:0] txn_size,
    input  logic                       txn_sup,
    input  logic [ADDR_W-1:0]          txn_addr,
    input  logic                       ack_err,
    output logic                       be_evt,
    output logic                       to_evt,
    output logic                       cur_wr,
    output logic [fault_pkg::SIZE_W-1:0] cur_size,
    output logic                       cur_sup,
    output logic [ADDR_W-1:0]          cur_addr
);
    import fault_pkg::*;

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic              busy;
        logic              wr;
        logic [SIZE_W-1:0] size;
        logic              sup;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } trk_t;

    trk_t st_d, st_q;
    logic expire;

    always_comb begin
        st_d   = st_q;
        expire = st_q.busy && st_q.wr && !txn_done && (st_q.cnt == CNT_LAST);
        if (txn_start) begin
            st_d.busy = 1'b1;
            st_d.wr   = txn_wr;
            st_d.size = txn_size;
            st_d.sup  = txn_sup;
            st_d.addr = txn_addr;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            if (txn_done || expire) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else if (st_q.wr) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign be_evt   = st_q.busy && st_q.wr && txn_done && ack_err;
    assign to_evt   = expire;
    assign cur_wr   = st_q.wr;
    assign cur_size = st_q.size;
    assign cur_sup  = st_q.sup;
    assign cur_addr = st_q.addr;

    // R3: counter never passes the limit
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LAST);
    // R3: an expired write is no longer outstanding
    a_r3_expire_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (to_evt && !txn_start) |=> !st_q.busy);
    // R2: reads never count toward a timeout
    a_r2_read_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !st_q.wr) |-> st_q.cnt == '0);
endmodule

// File: rtl/fault_capture.sv
module fault_capture #(
    parameter int ADDR_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_stat,
    input  logic                       late_evt,
    input  logic                       to_evt,
    input  logic                       be_evt,
    input  logic                       cur_wr,
    input  logic [fault_pkg::SIZE_W-1:0] cur_size,
    input  logic                       cur_sup,
    input  logic [ADDR_W-1:0]          cur_addr,
    output logic [31:0]                fault_stat_o,
    output logic [ADDR_W-1:0]          fault_addr_o,
    output logic                       irq_o
);
    import fault_pkg::*;

    typedef struct packed {
        cap_flags_t        f;
        logic [ADDR_W-1:0] addr;
    } cap_t;

    cap_t cap_d, cap_q;
    logic held_q;
    logic any_evt;

    assign held_q  = cap_q.f.late | cap_q.f.tmo | cap_q.f.berr;
    assign any_evt = late_evt | to_evt | be_evt;

    always_comb begin
        cap_d = cap_q;
        if (clr_stat) begin
            cap_d = '0;
        end else if (any_evt) begin
            if (!held_q) begin
                cap_d.f.late = late_evt;
                cap_d.f.tmo  = to_evt;
                cap_d.f.berr = be_evt;
                cap_d.f.size = cur_size;
                cap_d.f.sup  = cur_sup;
                cap_d.f.rd   = !cur_wr;
                cap_d.f.fav  = 1'b1;
                cap_d.addr   = cur_addr;
            end else begin
                cap_d.f.multi = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    always_comb begin
        fault_stat_o                 = '0;
        fault_stat_o[B_ERR]          = held_q;
        fault_stat_o[B_LATE]         = cap_q.f.late;
        fault_stat_o[B_TO]           = cap_q.f.tmo;
        fault_stat_o[B_BE]           = cap_q.f.berr;
        fault_stat_o[B_SZ_H:B_SZ_L]  = cap_q.f.size;
        fault_stat_o[B_SUP]          = cap_q.f.sup;
        fault_stat_o[23:20]          = RSV_PATTERN;
        fault_stat_o[B_ME]           = cap_q.f.multi;
        fault_stat_o[B_RD]           = cap_q.f.rd;
        fault_stat_o[B_FAV]          = cap_q.f.fav;
    end

    assign fault_addr_o = cap_q.addr;
    assign irq_o        = held_q;

    // R7: a held capture keeps its address
    a_r7_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !clr_stat) |=> $stable(cap_q.addr));
    // R7: multiple flag only with a held error
    a_r7_me_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.f.multi |-> held_q);
    // R8: clear empties everything
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stat |=> (!irq_o && cap_q.f == '0));
    // R6: a first error marks the address valid and raises the interrupt
    a_r6_first_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (any_evt && !held_q && !clr_stat) |=> (cap_q.f.fav && irq_o));
endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture #(
    parameter int ADDR_W      = 32,
    parameter int TIMEOUT_CYC = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              txn_done,
    input  logic              txn_wr,
    input  logic [2:0]        txn_size,
    input  logic              txn_sup,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              ack_err,
    input  logic              late_err,
    input  logic              clr_stat,
    output logic [31:0]       fault_stat_o,
    output logic [ADDR_W-1:0] fault_addr_o,
    output logic              irq_o
);
    logic              be_evt, to_evt, cur_wr, cur_sup;
    logic [2:0]        cur_size;
    logic [ADDR_W-1:0] cur_addr;

    fault_txn_track #(.ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_track (
        .clk(clk), .rst_n(rst_n),
        .txn_start(txn_start), .txn_done(txn_done), .txn_wr(txn_wr),
        .txn_size(txn_size), .txn_sup(txn_sup), .txn_addr(txn_addr),
        .ack_err(ack_err),
        .be_evt(be_evt), .to_evt(to_evt),
        .cur_wr(cur_wr), .cur_size(cur_size), .cur_sup(cur_sup), .cur_addr(cur_addr)
    );

    fault_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clr_stat(clr_stat),
        .late_evt(late_err), .to_evt(to_evt), .be_evt(be_evt),
        .cur_wr(cur_wr), .cur_size(cur_size), .cur_sup(cur_sup), .cur_addr(cur_addr),
        .fault_stat_o(fault_stat_o), .fault_addr_o(fault_addr_o), .irq_o(irq_o)
    );

    // R5: interrupt agrees with the latched error flags
    a_r5_irq_summary: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (fault_stat_o[30] | fault_stat_o[29] | fault_stat_o[28]));
endmodule

// File: tb/tb_bus_fault_capture.sv
module tb_bus_fault_capture;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT = 24;
    localparam logic [31:0] CLEAN = 32'h0080_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic txn_start = 0, txn_done = 0, txn_wr = 0, txn_sup = 0;
    logic ack_err = 0, late_err = 0, clr_stat = 0;
    logic [2:0]  txn_size = '0;
    logic [31:0] txn_addr = '0;
    logic [31:0] fault_stat_o, fault_addr_o;
    logic irq_o;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_fault_capture #(.ADDR_W(32), .TIMEOUT_CYC(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_done(txn_done),
        .txn_wr(txn_wr), .txn_size(txn_size), .txn_sup(txn_sup), .txn_addr(txn_addr),
        .ack_err(ack_err), .late_err(late_err), .clr_stat(clr_stat),
        .fault_stat_o(fault_stat_o), .fault_addr_o(fault_addr_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  size;
        logic        sup;
        logic [31:0] addr;
        logic        ack;
        logic        late;
        logic [7:0]  hold;
        logic        e_le, e_to, e_be, e_me, e_cap;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd2, 1'b1, 32'h1000_0040, 1'b1, 1'b0, 8'd3,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 write BE
        '{1'b1, 3'd5, 1'b0, 32'h2000_0100, 1'b0, 1'b0, 8'd24, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 timeout
        '{1'b0, 3'd1, 1'b1, 32'h3000_0008, 1'b1, 1'b0, 8'd2,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 read ack ignored
        '{1'b0, 3'd3, 1'b1, 32'h4000_0ff0, 1'b0, 1'b1, 8'd1,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 late on read
        '{1'b1, 3'd4, 1'b0, 32'h5000_0000, 1'b0, 1'b0, 8'd23, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 boundary
        '{1'b1, 3'd6, 1'b0, 32'h6000_0024, 1'b1, 1'b1, 8'd4,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1}  // R7 BE then late
    };

    function automatic logic [31:0] exp_stat(vec_t v);
        logic [31:0] s;
        if (!v.e_cap) return CLEAN;
        s = CLEAN;
        s[31] = v.e_le | v.e_to | v.e_be;
        s[30] = v.e_le; s[29] = v.e_to; s[28] = v.e_be;
        s[27:25] = v.size; s[24] = v.sup;
        s[19] = v.e_me; s[18] = ~v.wr; s[17] = 1'b1;
        return s;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic pulse_clear();
        @(negedge clk) clr_stat = 1;
        @(negedge clk) clr_stat = 0;
    endtask

    task automatic run_txn(vec_t v);
        @(negedge clk);
        txn_start = 1; txn_wr = v.wr; txn_size = v.size; txn_sup = v.sup; txn_addr = v.addr;
        @(negedge clk);
        txn_start = 0; txn_addr = 32'hdead_beef; txn_size = 3'd0;
        if (int'(v.hold) >= LIMIT) begin
            repeat (LIMIT + 1) @(negedge clk);
        end else begin
            repeat (int'(v.hold)) @(negedge clk);
            txn_done = 1; ack_err = v.ack;
            @(negedge clk);
            txn_done = 0; ack_err = 0;
        end
        if (v.late) begin
            late_err = 1;
            @(negedge clk);
            late_err = 0;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        vec_t w;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1, R9: reset state
        check("R1 stat", fault_stat_o, CLEAN);
        check("R1 addr", fault_addr_o, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            pulse_clear();
            run_txn(VECS[i]);
            check($sformatf("R6 vec%0d stat", i), fault_stat_o, exp_stat(VECS[i]));
            check($sformatf("R6 vec%0d addr", i), fault_addr_o,
                  VECS[i].e_cap ? VECS[i].addr : 32'h0);
            check($sformatf("R5 vec%0d irq", i), {31'b0, irq_o},
                  {31'b0, VECS[i].e_le | VECS[i].e_to | VECS[i].e_be});
        end

        // R7: a second error at another address keeps the first one
        pulse_clear();
        w = VECS[0];
        run_txn(w);
        run_txn('{1'b1, 3'd7, 1'b1, 32'h7777_0000, 1'b1, 1'b0, 8'd1,
                  1'b0, 1'b0, 1'b1, 1'b1, 1'b1});
        w.e_me = 1'b1;
        check("R7 stat", fault_stat_o, exp_stat(w));
        check("R7 addr", fault_addr_o, w.addr);

        // R8: clear wins over a same-cycle error
        @(negedge clk) clr_stat = 1; late_err = 1;
        @(negedge clk) clr_stat = 0; late_err = 0;
        check("R8 stat", fault_stat_o, CLEAN);
        check("R8 addr", fault_addr_o, 32'h0);
        check("R8 irq", {31'b0, irq_o}, 32'h0);

        // R9: reserved field after an error
        run_txn(VECS[1]);
        check("R9 rsv", {28'b0, fault_stat_o[23:20]}, 32'h8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule